// File: doc/BRIEF.md
# Priority-Resolved Load/Shift Register

This block is a small parameterised register (four bits by default) that accepts three independent requests: a parallel load, a right shift and a left shift. A priority encoder turns these requests into a two-bit operation code. The load request wins over both shifts, and a right shift wins over a left shift. When no request is active the code means hold. The code drives a four-way selector in front of every flip-flop, and each bit picks its own value, the parallel data bit, its upper neighbour or its lower neighbour.

On a right shift the serial right input enters at the most significant bit. On a left shift the serial left input enters at the least significant bit. A synchronous clear input zeroes the register and overrides every request. A synchronous reset does the same. The register only changes on a rising clock edge. The operation code is brought out combinationally so that a surrounding controller or a bench can watch which request won.

All pins are plain control and data levels sampled on each clock edge. The block has no handshake and applies no back-pressure: a request is acted on in the cycle it is presented.

Top module: `prio_shift_reg`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the register becomes all zeros after that edge.
- R2: While `clr` is high at a rising edge, the register becomes all zeros, whatever `load_req`, `rsh_req`, `lsh_req` and the data inputs are. `opc` still shows the encoded request.
- R3: `opc` is combinational from the requests and is encoded as follows: 2'b01 when `load_req` is high; otherwise 2'b10 when `rsh_req` is high; otherwise 2'b11 when `lsh_req` is high; otherwise 2'b00.
- R4: With code 2'b00 and no clear, the register keeps its value across the edge.
- R5: With code 2'b01 and no clear, the register takes `din` at the edge.
- R6: With code 2'b10 and no clear, bit i takes old bit i+1 and the top bit takes `rsh_in`.
- R7: With code 2'b11 and no clear, bit i takes old bit i-1 and bit 0 takes `lsh_in`.
- R8: When several requests are high together, only the winning request's operation takes effect on the register: load over right shift, and right shift over left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear to zero, overrides all requests |
| load_req | input | 1 | Parallel load request |
| rsh_req | input | 1 | Right shift request |
| lsh_req | input | 1 | Left shift request |
| din | input | W | Parallel load data |
| rsh_in | input | 1 | Serial bit entering at the MSB on a right shift |
| lsh_in | input | 1 | Serial bit entering at the LSB on a left shift |
| q | output | W | Register contents |
| opc | output | 2 | Resolved operation code |

## Verification
The embedded assertions check on every cycle the register's effect for each resolved code: hold, load, both shift directions, and the zeroing by clear. They also check that a load request always yields the load code. The bench's scenarios cover the rest. They sweep every combination of the three requests with clear low and with clear high over random data and serial bits, and they check the reset state, including a reset applied mid-run. The bench compares the resolved code, and the register against a behavioural model, on every step.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_LOAD = 2'b01,
    OP_SHR  = 2'b10,
    OP_SHL  = 2'b11
  } psr_op_e;
endpackage

// File: rtl/psr_prio_enc.sv
module psr_prio_enc
  import psr_pkg::*;
(
  input  logic    load_req,
  input  logic    rsh_req,
  input  logic    lsh_req,
  output psr_op_e op
);
  logic s0, s1;

  // low bit: load, or a lone left shift request
  assign s0 = load_req | (~load_req & ~rsh_req & lsh_req);
  // high bit: any shift request that is not overridden by load
  assign s1 = ~load_req & (rsh_req | lsh_req);

  assign op = psr_op_e'({s1, s0});
endmodule

// File: rtl/psr_bit_cell.sv
module psr_bit_cell
  import psr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  psr_op_e op,
  input  logic    par_bit,
  input  logic    hi_bit,
  input  logic    lo_bit,
  output logic    q
);
  logic nxt;

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = par_bit;
      OP_SHR:  nxt = hi_bit;
      OP_SHL:  nxt = lo_bit;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else            q <= nxt;
  end
endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import psr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load_req,
  input  logic         rsh_req,
  input  logic         lsh_req,
  input  logic [W-1:0] din,
  input  logic         rsh_in,
  input  logic         lsh_in,
  output logic [W-1:0] q,
  output logic [1:0]   opc
);
  localparam int MSB = W - 1;

  psr_op_e      op_w;
  logic [W-1:0] hi_src;
  logic [W-1:0] lo_src;

  psr_prio_enc u_enc (
    .load_req (load_req),
    .rsh_req  (rsh_req),
    .lsh_req  (lsh_req),
    .op       (op_w)
  );

  assign opc = op_w;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign hi_src[i] = rsh_in;
    end else begin : g_mid_hi
      assign hi_src[i] = q[i+1];
    end
    if (i == 0) begin : g_bot
      assign lo_src[i] = lsh_in;
    end else begin : g_mid_lo
      assign lo_src[i] = q[i-1];
    end

    psr_bit_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .op      (op_w),
      .par_bit (din[i]),
      .hi_bit  (hi_src[i]),
      .lo_bit  (lo_src[i]),
      .q       (q[i])
    );
  end

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_req |-> opc == 2'b01);

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && opc == 2'b00) |=> $stable(q));

  // R5
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && opc == 2'b01) |=> q == $past(din));

  // R6
  shr_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && opc == 2'b10) |=> q == {$past(rsh_in), $past(q[W-1:1])});

  // R7
  shl_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && opc == 2'b11) |=> q == {$past(q[W-2:0]), $past(lsh_in)});
endmodule

// File: tb/prio_shift_reg_test.sv
module prio_shift_reg_test;
  localparam int W = 4;
  localparam int CLK_P = 10;
  localparam int WDOG = 20000;

  logic         clk = 1'b0;
  logic         rst, clr, load_req, rsh_req, lsh_req, rsh_in, lsh_in;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic [1:0]   opc;

  int checks = 0;
  int errors = 0;
  int model = 0;
  int mask = (1 << W) - 1;
  bit done = 0;

  prio_shift_reg #(.W(W)) uut (
    .clk(clk), .rst(rst), .clr(clr), .load_req(load_req), .rsh_req(rsh_req),
    .lsh_req(lsh_req), .din(din), .rsh_in(rsh_in), .lsh_in(lsh_in),
    .q(q), .opc(opc)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one step: drive, check code, clock, check register against model
  task automatic step(input bit c, input bit l, input bit r, input bit s,
                      input int d, input bit ri, input bit li);
    int eop;
    string tag;
    clr = c; load_req = l; rsh_req = r; lsh_req = s;
    din = d[W-1:0]; rsh_in = ri; lsh_in = li;
    #1;
    if (l)      eop = 1;
    else if (r) eop = 2;
    else if (s) eop = 3;
    else        eop = 0;
    chk("R3 opcode", int'(opc), eop);
    if (c) begin
      model = 0; tag = "R2 clear";
    end else begin
      case (eop)
        1: begin model = d & mask; tag = "R5 load"; end
        2: begin model = (model >> 1) | (int'(ri) << (W-1)); tag = "R6 shift right"; end
        3: begin model = ((model << 1) | int'(li)) & mask; tag = "R7 shift left"; end
        default: tag = "R4 hold";
      endcase
      if ((int'(l) + int'(r) + int'(s)) > 1) tag = {tag, " R8 priority"};
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(q), model);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; clr = 0; load_req = 0; rsh_req = 0; lsh_req = 0;
    din = '0; rsh_in = 0; lsh_in = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model = 0;
    chk("R1 reset state", int'(q), 0);
    rst = 0;

    // directed: load then walk right and left
    step(0, 1, 0, 0, 4'hA, 0, 0);
    step(0, 0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 4'h5, 1, 1);
    step(0, 1, 1, 1, 4'h3, 0, 0);
    step(0, 0, 1, 1, 0, 0, 1);

    // sweep every request combination, clear low and high, random data
    for (int it = 0; it < 200; it++) begin
      for (int k = 0; k < 16; k++) begin
        step(k[3] & (it[1:0] == 2'b00), k[2], k[1], k[0],
             int'($urandom), $urandom % 2 == 1, $urandom % 2 == 1);
      end
    end

    // reset in the middle of a run
    step(0, 1, 0, 0, 4'hF, 0, 0);
    rst = 1; load_req = 1; din = 4'h9;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    model = 0;
    chk("R1 reset mid-run", int'(q), 0);

    // clear beats a load request
    step(0, 1, 0, 0, 4'hC, 0, 0);
    step(1, 1, 0, 0, 4'h7, 1, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule